// File: doc/BRIEF.md
# Table-Scheduled Hub Access Arbiter

Several processor cores share one memory hub, and this block decides which core owns the hub in each clock cycle. A rewritable schedule of 128 slots holds one core number per slot. A free-running slot pointer steps through the schedule once per clock, so the owner of each cycle depends only on what the schedule holds. The grant never depends on which cores happen to be asking.

Software can change the schedule one slot per clock through a write port. A heavy user, such as a display refresh engine, can be given many slots, and a light user, such as a serial link, only a few. A slot whose owner is not requesting goes unused. Both outputs are registered, and the schedule starts only after the reset release has passed through an internal two-stage synchronizer.

Top module: `hub_slot_arbiter`

## Requirements
- R1: While `rst_ni` is low, `grant_o` is all zero and `owner_o` is zero.
- R2: After reset, slot k holds core k mod 16. The first 128 owners shown after the schedule starts are therefore 0,1,...,15, repeated eight times.
- R3: The slot pointer advances by one on every functional clock and wraps from slot 127 to slot 0. With an unchanged schedule, the owner sequence repeats every 128 cycles.
- R4: `grant_o` has at most one bit set, and that bit is bit `owner_o`. `owner_o` and `grant_o` appear one clock after their slot is read. The grant bit is set when the owning core's `req_i` bit was high at that read edge.
- R5: If the owner of a slot is not requesting, `grant_o` is all zero for that slot. No other core receives the slot, even if it is requesting.
- R6: The sequence on `owner_o` depends only on the schedule contents and never on `req_i`.
- R7: When `wr_en_i` is high at a rising edge, slot `wr_slot_i` takes the value `wr_core_i` at that edge. A slot read on that same edge still uses the old value, and a read on any later edge uses the new value.
- R8: Hub share follows slot count. After slot numbers 3, 19, 35, ..., 115 are rewritten to core 5, core 5 is granted 16 times and core 3 zero times over 128 cycles in which all cores request.
- R9: The schedule starts on the third rising edge after `rst_ni` goes high. Writes presented on the two edges before that are discarded, and the outputs stay zero until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| req_i | input | 16 | Per-core hub request, bit n belongs to core n |
| wr_en_i | input | 1 | Schedule write enable |
| wr_slot_i | input | 7 | Schedule slot to write |
| wr_core_i | input | 4 | Core number stored in the written slot |
| grant_o | output | 16 | Registered one-hot grant, all zero for an unused slot |
| owner_o | output | 4 | Registered owner of the current slot, shown even when the slot goes unused |

## Verification
The two functions that can fall in the same cycle are a schedule write and the read of the same slot by the pointer. The bench provokes this by writing to the slot its own model says the pointer reads at the next edge, and also to the slot after that, while every core is requesting. The result is judged against a behavioural model: the colliding read must show the old owner, and the following read must show the new one. The bench also puts writes inside the two-edge reset synchronizer window and shows they are dropped.

// File: rtl/hub_arb_pkg.sv
package hub_arb_pkg;
  localparam int unsigned HUB_CORES = 16;
  localparam int unsigned HUB_SLOTS = 128;
endpackage

// File: rtl/hub_rst_sync.sv
module hub_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_no = stage2_q;
endmodule

// File: rtl/hub_slot_ptr.sv
module hub_slot_ptr #(
  parameter int unsigned SLOTS = 128,
  localparam int unsigned PTR_W = $clog2(SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(SLOTS - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  assign ptr_en = 1'b1;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_en) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/hub_slot_table.sv
module hub_slot_table #(
  parameter int unsigned CORES = 16,
  parameter int unsigned SLOTS = 128,
  localparam int unsigned CORE_W = $clog2(CORES),
  localparam int unsigned PTR_W  = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  output logic [CORE_W-1:0] rd_owner_o,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_slot_i,
  input  logic [CORE_W-1:0] wr_core_i
);
  localparam logic [PTR_W:0] SLOT_LIMIT = (PTR_W + 1)'(SLOTS);

  logic [CORE_W-1:0] tab_q [SLOTS];
  logic [CORE_W-1:0] tab_d [SLOTS];
  logic              wr_ok;

  assign wr_ok = wr_en_i && ({1'b0, wr_slot_i} < SLOT_LIMIT);

  always_comb begin
    for (int i = 0; i < int'(SLOTS); i++) begin
      tab_d[i] = tab_q[i];
    end
    if (wr_ok) tab_d[wr_slot_i] = wr_core_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(SLOTS); i++) begin
        tab_q[i] <= CORE_W'(i % int'(CORES));
      end
    end else begin
      for (int i = 0; i < int'(SLOTS); i++) begin
        tab_q[i] <= tab_d[i];
      end
    end
  end

  assign rd_owner_o = tab_q[rd_ptr_i];
endmodule

// File: rtl/hub_grant_reg.sv
module hub_grant_reg #(
  parameter int unsigned CORES = 16,
  localparam int unsigned CORE_W = $clog2(CORES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CORE_W-1:0] slot_owner_i,
  input  logic [CORES-1:0]  req_i,
  output logic [CORES-1:0]  grant_o,
  output logic [CORE_W-1:0] owner_o
);
  logic [CORES-1:0]  grant_d, grant_q;
  logic [CORE_W-1:0] owner_q;

  for (genvar j = 0; j < int'(CORES); j++) begin : g_dec
    assign grant_d[j] = (slot_owner_i == CORE_W'(j)) && req_i[j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= '0;
      owner_q <= '0;
    end else begin
      grant_q <= grant_d;
      owner_q <= slot_owner_i;
    end
  end

  assign grant_o = grant_q;
  assign owner_o = owner_q;
endmodule

// File: rtl/hub_slot_arbiter.sv
module hub_slot_arbiter
  import hub_arb_pkg::*;
#(
  parameter int unsigned CORES = HUB_CORES,
  parameter int unsigned SLOTS = HUB_SLOTS,
  localparam int unsigned CORE_W = $clog2(CORES),
  localparam int unsigned PTR_W  = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CORES-1:0]  req_i,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_slot_i,
  input  logic [CORE_W-1:0] wr_core_i,
  output logic [CORES-1:0]  grant_o,
  output logic [CORE_W-1:0] owner_o
);
  logic              rst_sync_n;
  logic [PTR_W-1:0]  slot_ptr;
  logic [CORE_W-1:0] slot_owner;

  hub_rst_sync u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  hub_slot_ptr #(.SLOTS(SLOTS)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .ptr_o (slot_ptr)
  );

  hub_slot_table #(.CORES(CORES), .SLOTS(SLOTS)) u_tab (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .rd_ptr_i  (slot_ptr),
    .rd_owner_o(slot_owner),
    .wr_en_i   (wr_en_i),
    .wr_slot_i (wr_slot_i),
    .wr_core_i (wr_core_i)
  );

  hub_grant_reg #(.CORES(CORES)) u_gnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .slot_owner_i(slot_owner),
    .req_i       (req_i),
    .grant_o     (grant_o),
    .owner_o     (owner_o)
  );
endmodule

// File: rtl/hub_slot_arbiter_chk.sv
module hub_slot_arbiter_chk #(
  parameter int unsigned CORES = 16,
  parameter int unsigned SLOTS = 128,
  localparam int unsigned CORE_W = $clog2(CORES),
  localparam int unsigned PTR_W  = $clog2(SLOTS)
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic [CORES-1:0]  req_i,
  input logic              wr_en_i,
  input logic [PTR_W-1:0]  wr_slot_i,
  input logic [CORE_W-1:0] wr_core_i,
  input logic [PTR_W-1:0]  rd_ptr,
  input logic [CORE_W-1:0] rd_owner,
  input logic [CORES-1:0]  grant_o,
  input logic [CORE_W-1:0] owner_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(SLOTS - 1);
  logic [PTR_W-1:0] nxt_ptr;

  assign nxt_ptr = (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);

  assert_grant_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_grant_is_owner_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (grant_o != '0) |-> grant_o[owner_o]);

  assert_used_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    req_i[rd_owner] |=> (grant_o[owner_o] && owner_o == $past(rd_owner)));

  assert_idle_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    !req_i[rd_owner] |=> (grant_o == '0));

  assert_ptr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> rd_ptr == $past(nxt_ptr));

  assert_same_slot_write_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && wr_slot_i == rd_ptr) |=> owner_o == $past(rd_owner));

  assert_next_slot_write_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && wr_slot_i == nxt_ptr) |=> rd_owner == $past(wr_core_i));
endmodule

bind hub_slot_arbiter hub_slot_arbiter_chk #(.CORES(CORES), .SLOTS(SLOTS)) u_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_sync_n),
  .req_i    (req_i),
  .wr_en_i  (wr_en_i),
  .wr_slot_i(wr_slot_i),
  .wr_core_i(wr_core_i),
  .rd_ptr   (slot_ptr),
  .rd_owner (slot_owner),
  .grant_o  (grant_o),
  .owner_o  (owner_o)
);

// File: tb/sim_hub_slot_arbiter.sv
`timescale 1ns/1ps
module sim_hub_slot_arbiter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] req;
  logic        we;
  logic [6:0]  wslot;
  logic [3:0]  wcore;
  logic [15:0] grant_o;
  logic [3:0]  owner_o;

  int compared = 0;
  int mismatched = 0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference
  int          m_tab [128];
  int          m_ptr;
  int          m_sync;
  logic [15:0] m_grant;
  logic [3:0]  m_owner;

  always #4 clk = ~clk;

  hub_slot_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_en_i(we),
    .wr_slot_i(wslot), .wr_core_i(wcore), .grant_o(grant_o), .owner_o(owner_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 128; k++) m_tab[k] = k % 16;
      m_ptr = 0; m_sync = 0; m_grant = '0; m_owner = '0;
    end else if (m_sync < 2) begin
      m_sync = m_sync + 1;
    end else begin
      int own;
      own = m_tab[m_ptr];
      m_owner = own[3:0];
      m_grant = req[own] ? (16'h1 << own) : 16'h0;
      if (we) m_tab[wslot] = wcore;
      m_ptr = (m_ptr + 1) % 128;
    end
  end

  task automatic check(input string tag);
    compared++;
    if (grant_o !== m_grant || owner_o !== m_owner) begin
      mismatched++;
      $display("FAIL %s: grant=%h owner=%0d expected grant=%h owner=%0d",
               tag, grant_o, owner_o, m_grant, m_owner);
    end
  endtask

  task automatic tick(input string tag);
    @(negedge clk);
    check(tag);
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int cnt5, cnt3;
    rst_n = 1'b0; req = '1; we = 1'b0; wslot = '0; wcore = '0;
    // R1: reset state with every core requesting
    repeat (3) tick("R1");
    // R9: release, and try a write inside the synchronizer window
    rst_n = 1'b1; we = 1'b1; wslot = 7'd0; wcore = 4'd9;
    tick("R9");
    tick("R9");
    we = 1'b0;
    // R2: default fill shows 0..15 eight times
    for (int c = 0; c < 128; c++) begin
      tick("R2");
      if (owner_o !== 4'(c % 16)) begin
        mismatched++;
        $display("FAIL R2: owner=%0d expected=%0d", owner_o, c % 16);
      end
      compared++;
    end
    // R3: wrap and repeat
    for (int c = 0; c < 130; c++) tick("R3");
    // R5: half the cores idle
    req = 16'h5A5A;
    for (int c = 0; c < 64; c++) tick("R5");
    req = 16'h0000;
    for (int c = 0; c < 20; c++) tick("R5");
    // R4 and R6: request pattern changing every cycle
    for (int c = 0; c < 200; c++) begin
      step_lfsr(); req = lfsr;
      tick(c < 100 ? "R4" : "R6");
    end
    // R7: writes to the slot read at the next edge, and to the one after it
    req = '1;
    for (int c = 0; c < 24; c++) begin
      we = 1'b1;
      wslot = (c % 2 == 0) ? 7'(m_ptr) : 7'((m_ptr + 1) % 128);
      wcore = 4'((m_tab[wslot] + 7) % 16);
      tick("R7");
    end
    we = 1'b0;
    for (int c = 0; c < 130; c++) tick("R7");
    // R8: hand every slot of core 3 to core 5 after restoring the default fill
    for (int s = 0; s < 128; s++) begin
      we = 1'b1; wslot = 7'(s);
      wcore = (s % 16 == 3) ? 4'd5 : 4'(s % 16);
      tick("R8");
    end
    we = 1'b0;
    tick("R8");
    cnt5 = 0; cnt3 = 0;
    for (int c = 0; c < 128; c++) begin
      tick("R8");
      if (grant_o[5]) cnt5++;
      if (grant_o[3]) cnt3++;
    end
    compared++;
    if (cnt5 != 16) begin
      mismatched++;
      $display("FAIL R8: core5 grants=%0d expected=16", cnt5);
    end
    compared++;
    if (cnt3 != 0) begin
      mismatched++;
      $display("FAIL R8: core3 grants=%0d expected=0", cnt3);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule